// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with lookahead adder and recoded multiplier

This block is a purely combinational ALU for two 8-bit operands. A 3-bit operation code picks one of eight functions. Three are arithmetic: plain addition, addition with an incoming carry, and signed multiplication. Five are bitwise: AND, OR, XOR, XNOR and NOR. The result is 16 bits wide, so a full product fits without truncation. Two flags come with it: a carry-out and a zero indication.

Addition uses a carry-lookahead adder built from 4-bit groups. Multiplication uses a radix-4 Booth recoded multiplier, which halves the number of partial products to four. Both live in their own submodules. The top level holds the bitwise unit and the result selector. There is no clock and no state: the outputs follow the inputs.

Top module: `alu8_mixed`

## Requirements
- R1: Opcode 3'b000 gives the unsigned sum a+b in result bits 7:0 and the carry-out in bit 8. Bits 15:9 are zero, and the carry input has no effect.
- R2: Opcode 3'b001 gives a+b+carry_i, laid out as in R1.
- R3: Opcode 3'b010 gives the product of a and b, both read as two's-complement numbers, as a 16-bit two's-complement result.
- R4: Opcode 3'b011 gives the bitwise AND of a and b in bits 7:0, with bits 15:8 zero.
- R5: Opcode 3'b100 gives the bitwise OR of a and b in bits 7:0, with bits 15:8 zero.
- R6: Opcode 3'b101 gives the bitwise XOR of a and b in bits 7:0, with bits 15:8 zero.
- R7: Opcode 3'b110 gives the bitwise XNOR of a and b in bits 7:0, with bits 15:8 zero.
- R8: Opcode 3'b111 gives the bitwise NOR of a and b in bits 7:0, with bits 15:8 zero.
- R9: carry_o equals the adder's carry-out for opcodes 000 and 001, and is 0 for every other opcode.
- R10: zero_o is 1 exactly when all 16 result bits are 0.
- R11: The outputs depend only on the present inputs, with no clock or stored state. A change of inputs shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand (multiplicand) |
| b_i | input | 8 | Second operand (multiplier) |
| carry_i | input | 1 | Carry input, used by opcode 001 only |
| op_i | input | 3 | Operation code |
| result_o | output | 16 | Result |
| carry_o | output | 1 | Carry-out of the addition |
| zero_o | output | 1 | Result-is-zero flag |

## Verification
The bench aims at the addition carry chain at its extremes. It uses 0xFF+0x01, where a broken lookahead term would drop the carry across the group boundary. It uses 0xFF+0xFF with carry-in, where the carry must reach bit 8. It also applies a carry-in to plain add, which must have no effect. For multiplication it drives the operands that stress Booth recoding: -128 times -128, -128 times 127, and -1 times 1. A wrong sign extension or negation of a partial product shows up there as a wrong upper byte. For the bitwise functions it drives operand pairs that make XNOR and NOR return zero, so a swapped opcode or a missing zero flag is caught. A long pseudo-random sweep, compared against a behavioural model, covers the remaining cases.

// File: rtl/alu8_cla_adder.sv
module alu8_cla_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NG = W / 4;

  logic [W-1:0] g, p;
  logic [W:0]   c;

  assign g    = x_i & y_i;
  assign p    = x_i ^ y_i;
  assign c[0] = cin_i;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    localparam int B = 4 * gi;
    logic grp_g, grp_p;
    assign c[B+1] = g[B] | (p[B] & c[B]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & c[B]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                  | (p[B+2] & p[B+1] & p[B] & c[B]);
    assign grp_g  = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                  | (p[B+3] & p[B+2] & p[B+1] & g[B]);
    assign grp_p  = &p[B+3:B];
    assign c[B+4] = grp_g | (grp_p & c[B]);
  end

  assign sum_o  = p ^ c[W-1:0];
  assign cout_o = c[W];
endmodule

// File: rtl/alu8_booth_mul.sv
module alu8_booth_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW  = 2 * W;
  localparam int DIG = W / 2;

  logic [PW-1:0] ax;
  logic [W:0]    bx;
  logic [PW-1:0] pp [DIG];

  assign ax = {{W{mcand_i[W-1]}}, mcand_i};
  assign bx = {mplier_i, 1'b0};

  for (genvar d = 0; d < DIG; d++) begin : g_dig
    logic [2:0]    trip;
    logic [PW-1:0] mag;
    logic          neg;
    assign trip = bx[2*d+2 -: 3];
    always_comb begin
      unique case (trip)
        3'b001, 3'b010: begin mag = ax;        neg = 1'b0; end
        3'b011:         begin mag = ax << 1;   neg = 1'b0; end
        3'b100:         begin mag = ax << 1;   neg = 1'b1; end
        3'b101, 3'b110: begin mag = ax;        neg = 1'b1; end
        default:        begin mag = '0;        neg = 1'b0; end
      endcase
    end
    assign pp[d] = (neg ? (~mag + PW'(1)) : mag) << (2 * d);
  end

  always_comb begin
    prod_o = '0;
    for (int k = 0; k < DIG; k++) prod_o = prod_o + pp[k];
  end
endmodule

// File: rtl/alu8_mixed.sv
module alu8_mixed #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           carry_i,
  input  logic [2:0]     op_i,
  output logic [2*W-1:0] result_o,
  output logic           carry_o,
  output logic           zero_o
);
  localparam int RW = 2 * W;
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADC  = 3'd1;
  localparam logic [2:0] OP_MUL  = 3'd2;
  localparam logic [2:0] OP_AND  = 3'd3;
  localparam logic [2:0] OP_OR   = 3'd4;
  localparam logic [2:0] OP_XOR  = 3'd5;
  localparam logic [2:0] OP_XNOR = 3'd6;

  logic [W-1:0]  sum, lu;
  logic          add_c, is_add;
  logic [RW-1:0] prod;

  assign is_add = (op_i == OP_ADD) || (op_i == OP_ADC);

  alu8_cla_adder #(.W(W)) add_i (
    .x_i(a_i), .y_i(b_i), .cin_i((op_i == OP_ADC) & carry_i),
    .sum_o(sum), .cout_o(add_c)
  );

  alu8_booth_mul #(.W(W)) mul_i (
    .mcand_i(a_i), .mplier_i(b_i), .prod_o(prod)
  );

  always_comb begin
    unique case (op_i)
      OP_AND:  lu = a_i & b_i;
      OP_OR:   lu = a_i | b_i;
      OP_XOR:  lu = a_i ^ b_i;
      OP_XNOR: lu = ~(a_i ^ b_i);
      default: lu = ~(a_i | b_i);
    endcase
  end

  always_comb begin
    if (is_add)              result_o = {{(W-1){1'b0}}, add_c, sum};
    else if (op_i == OP_MUL) result_o = prod;
    else                     result_o = {{W{1'b0}}, lu};
  end

  assign carry_o = is_add & add_c;
  assign zero_o  = (result_o == '0);
endmodule

// File: rtl/alu8_mixed_chk.sv
module alu8_mixed_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           carry_i,
  input logic [2:0]     op_i,
  input logic [2*W-1:0] result_o,
  input logic           carry_o,
  input logic           zero_o
);
  localparam int RW = 2 * W;

  always_comb begin
    if (op_i == 3'd0)
      AST_ADD_SUM: assert (result_o == RW'(a_i) + RW'(b_i)) else $error("add sum"); // R1
    if (op_i == 3'd1)
      AST_ADC_SUM: assert (result_o == RW'(a_i) + RW'(b_i) + RW'(carry_i)) else $error("adc sum"); // R2
    if (op_i == 3'd2)
      AST_MUL_PRODUCT: assert ($signed(result_o) == $signed(a_i) * $signed(b_i)) else $error("product"); // R3
    if (op_i >= 3'd3)
      AST_LOGIC_UPPER_ZERO: assert (result_o[RW-1:W] == '0) else $error("logic upper"); // R8
    if (op_i == 3'd3)
      AST_AND_BITS: assert (result_o[W-1:0] == (a_i & b_i)) else $error("and"); // R4
    if (op_i >= 3'd2)
      AST_NO_CARRY_OUT: assert (!carry_o) else $error("carry"); // R9
    if (op_i <= 3'd1)
      AST_CARRY_BIT8: assert (carry_o == result_o[W]) else $error("carry bit"); // R9
    if (zero_o)
      AST_ZERO_LOW: assert (result_o[W-1:0] == '0) else $error("zero flag"); // R10
  end
endmodule

bind alu8_mixed alu8_mixed_chk #(.W(W)) chk_i (
  .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .op_i(op_i),
  .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
);

// File: tb/alu8_mixed_tb_top.sv
`timescale 1ns/1ps
module alu8_mixed_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  a, b;
  logic        cin;
  logic [2:0]  op;
  logic [15:0] res;
  logic        cout, zf;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu8_mixed dut_i (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .result_o(res), .carry_o(cout), .zero_o(zf)
  );

  // op[37:35] a[34:27] b[26:19] cin[18] res[17:2] carry[1] zero[0]
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 8'h00, 8'h00, 1'b1, 16'h0000, 1'b0, 1'b1},  // R1 cin ignored, R10
    {3'd0, 8'hFF, 8'h01, 1'b0, 16'h0100, 1'b1, 1'b0},  // R1 R9
    {3'd1, 8'hFF, 8'h00, 1'b1, 16'h0100, 1'b1, 1'b0},  // R2
    {3'd1, 8'h12, 8'h34, 1'b1, 16'h0047, 1'b0, 1'b0},  // R2
    {3'd1, 8'hFF, 8'hFF, 1'b1, 16'h01FF, 1'b1, 1'b0},  // R2 R9
    {3'd2, 8'h03, 8'h05, 1'b1, 16'h000F, 1'b0, 1'b0},  // R3
    {3'd2, 8'hFF, 8'h01, 1'b0, 16'hFFFF, 1'b0, 1'b0},  // R3
    {3'd2, 8'h80, 8'h80, 1'b0, 16'h4000, 1'b0, 1'b0},  // R3
    {3'd2, 8'h80, 8'h7F, 1'b0, 16'hC080, 1'b0, 1'b0},  // R3
    {3'd2, 8'h00, 8'hA5, 1'b0, 16'h0000, 1'b0, 1'b1},  // R3 R10
    {3'd2, 8'h7F, 8'h7F, 1'b0, 16'h3F01, 1'b0, 1'b0},  // R3
    {3'd3, 8'hF0, 8'h3C, 1'b0, 16'h0030, 1'b0, 1'b0},  // R4
    {3'd4, 8'hF0, 8'h0C, 1'b0, 16'h00FC, 1'b0, 1'b0},  // R5
    {3'd5, 8'hAA, 8'hFF, 1'b0, 16'h0055, 1'b0, 1'b0},  // R6
    {3'd6, 8'hAA, 8'h55, 1'b0, 16'h0000, 1'b0, 1'b1},  // R7 R10
    {3'd7, 8'h00, 8'h00, 1'b1, 16'h00FF, 1'b0, 1'b0},  // R8
    {3'd7, 8'hF0, 8'h0F, 1'b0, 16'h0000, 1'b0, 1'b1}   // R8 R10
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%0d a=%h b=%h cin=%b got res=%h c=%b z=%b expected res=%h c=%b z=%b",
               req, op, a, b, cin, act[17:2], act[1], act[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [17:0] model(input logic [2:0] o, input logic [7:0] x, y, input logic ci);
    logic [15:0] r;
    logic        c;
    c = 1'b0;
    case (o)
      3'd0: begin r = {7'd0, {1'b0, x} + {1'b0, y}}; c = r[8]; end
      3'd1: begin r = {7'd0, {1'b0, x} + {1'b0, y} + {8'd0, ci}}; c = r[8]; end
      3'd2: r = 16'($signed(x) * $signed(y));
      3'd3: r = {8'd0, x & y};
      3'd4: r = {8'd0, x | y};
      3'd5: r = {8'd0, x ^ y};
      3'd6: r = {8'd0, x ~^ y};
      default: r = {8'd0, ~(x | y)};
    endcase
    return {r, c, r == 16'd0};
  endfunction

  initial begin
    a = 8'h00; b = 8'h00; cin = 1'b0; op = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset state", {res, cout, zf}, {16'h0000, 1'b0, 1'b1});
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, a, b, cin} = VEC[i][37:18];
      #5;
      check($sformatf("vector %0d (R1-style table, see comment)", i), {res, cout, zf}, VEC[i][17:0]);
    end

    // R11: outputs follow inputs between clock edges, no edge needed
    @(posedge clk);
    #2 op = 3'd0; a = 8'h0F; b = 8'h01; cin = 1'b0;
    #1 check("R11 add without edge", {res, cout, zf}, {16'h0010, 1'b0, 1'b0});
    #1 op = 3'd2; a = 8'hFE; b = 8'h03;
    #1 check("R11 mul without edge", {res, cout, zf}, {16'hFFFA, 1'b0, 1'b0});

    // R9: carry-in on multiply/logic never produces carry_o
    @(negedge clk);
    op = 3'd3; a = 8'hFF; b = 8'hFF; cin = 1'b1;
    #5 check("R9 no carry on AND", {res, cout, zf}, {16'h00FF, 1'b0, 1'b0});

    // sweep all opcodes against the behavioural model
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a = lfsr[7:0];
        b = lfsr[15:8] ^ 8'(k);
        op = 3'(k);
        cin = lfsr[3];
        #5 check("R1..R10 sweep", {res, cout, zf}, model(op, a, b, cin));
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule